// File: doc/BRIEF.md
# Capture/Compare Counter Array

This block is a shared 16-bit time base that feeds five independent capture/compare cells. The time base advances on one of three strobes. A fixed internal prescaler is one of them. A one-cycle overflow pulse from a neighbouring timer is another. A rising edge on an external pin is the third. A run bit gates the count, and an idle-stop option freezes it while the chip is idle. Every wrap of the counter past all ones sets an overflow flag.

Each cell owns a 7-bit mode register and a 16-bit capture/compare value. A cell can latch the counter on a rising edge, a falling edge or both edges of its own capture pin. It can compare the counter against its value to raise a flag, to invert its output, or to do both. In its third use it drives an 8-bit pulse-width output whose duty is reloaded once per low-byte period. Software clears the flags by writing zeros. The single interrupt line is the OR of every flag whose enable is set.

The host reaches all state through a byte-wide port with a 5-bit address. Writes take effect on the clock edge that samples them, and a read returns the addressed byte one cycle later.

Top module: `cca_top`

## Requirements
- R1: Bit 6 of the control byte (offset 0) is the run bit. While it is 0, no count strobe changes the counter. The counter low and high bytes sit at offsets 2 and 3 and can be written at any time.
- R2: A counted strobe that arrives at 0xFFFF wraps the counter to 0x0000 and sets the overflow flag, which is bit 7 of the control byte and is also driven on `ovf_flag`.
- R3: Bits 2:1 of the config byte (offset 1) pick the count source. With codes 00 and 01 the counter advances once every DIV enabled cycles (DIV=6), and the prescaler restarts from zero whenever counting is disabled.
- R4: Code 10 counts each cycle in which `tmr_ovf` is high. Code 11 counts each rising edge of `ext_cnt`, taken after a two-flop synchronizer.
- R5: A cell with compare enable (mode bit 6) and match-flag enable (mode bit 3) sets its flag, bit i of the control byte, when the counter advances onto its capture/compare value. Mode bytes are at offset 8+i, value low bytes at 16+i and high bytes at 24+i.
- R6: Mode bit 5 captures the counter on a rising edge and mode bit 4 captures it on a falling edge of the synchronized `cap_in[i]`. A capture stores the counter value of the detection cycle and sets the cell flag. An edge of a kind that is not enabled changes nothing.
- R7: With compare enable and toggle enable (mode bit 2), the cell output inverts on every match. Without match-flag enable, the match leaves the flag clear.
- R8: In PWM mode (mode bit 1), `mod_out[i]` is 0 while the counter low byte is below the value low byte and 1 otherwise. When the counter low byte wraps to zero, the value high byte is copied into the value low byte.
- R9: With idle-stop (config bit 7) set, the counter holds while `idle` is high. With idle-stop clear, `idle` has no effect.
- R10: `irq` is registered and equals the OR of the overflow flag ANDed with overflow enable (config bit 0) and each cell flag ANDed with its mode bit 0.
- R11: Writing the control byte clears every flag whose data bit is 0 and leaves unchanged every flag whose data bit is 1. A flag never becomes set through a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_ovf | input | 1 | Count strobe from a neighbouring timer |
| ext_cnt | input | 1 | External count pin (asynchronous) |
| cap_in | input | NMOD | Per-cell capture pins (asynchronous) |
| idle | input | 1 | Chip idle indication |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address for both write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data for `addr` |
| mod_out | output | NMOD | Cell outputs (toggle or PWM) |
| irq | output | 1 | Combined interrupt |
| ovf_flag | output | 1 | Counter overflow flag |
| mod_flag | output | NMOD | Per-cell flags |

## Verification
A corrupted counter shows up at the first read of offsets 2 and 3. It also shows as a flag or toggle that fires one advance early or late, because compare is checked only on the cycle after an advance. A wrong capture latch or a stuck PWM reload byte reads back wrong one cycle after the read address is set. A PWM output computed from a stale low byte is wrong on `mod_out` a single cycle after the counter write. A flag register that drops or gains bits is seen on `irq` one cycle later and on the control byte at the next read.

// File: rtl/cca_pkg.sv
package cca_pkg;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRL   = 5'd0;
  localparam logic [ADDR_W-1:0] A_CFG    = 5'd1;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 5'd2;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 5'd3;
  localparam int B_MODE = 8;
  localparam int B_VLO  = 16;
  localparam int B_VHI  = 24;

  typedef enum logic [1:0] {
    SRC_DIV_A = 2'b00,
    SRC_DIV_B = 2'b01,
    SRC_TMR   = 2'b10,
    SRC_EXT   = 2'b11
  } src_e;

  typedef struct packed {
    logic cmp_en;
    logic cap_pos;
    logic cap_neg;
    logic match_en;
    logic tog_en;
    logic pwm_en;
    logic flag_ie;
  } mode_t;
endpackage

// File: rtl/cca_timebase.sv
module cca_timebase
  import cca_pkg::*;
#(
  parameter int DIV = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             idle,
  input  logic             idle_stop,
  input  src_e             src,
  input  logic             tmr_ovf,
  input  logic             ext_cnt,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       wr_data,
  output logic [CNT_W-1:0] cnt,
  output logic             adv,
  output logic             ovf
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PMAX = PW'(DIV - 1);

  logic [PW-1:0] pre;
  logic ext_s1, ext_s2, ext_s3;
  logic en, tick, ext_rise, host_wr;

  assign en       = run & ~(idle & idle_stop);
  assign ext_rise = ext_s2 & ~ext_s3;
  assign host_wr  = wr_lo | wr_hi;

  always_comb begin
    unique case (src)
      SRC_TMR: tick = en & tmr_ovf;
      SRC_EXT: tick = en & ext_rise;
      default: tick = en & (pre == PMAX);
    endcase
  end

  assign ovf = tick & ~host_wr & (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_s1 <= 1'b0;
      ext_s2 <= 1'b0;
      ext_s3 <= 1'b0;
    end else begin
      ext_s1 <= ext_cnt;
      ext_s2 <= ext_s1;
      ext_s3 <= ext_s2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en || src[1]) pre <= '0;
    else if (pre == PMAX)     pre <= '0;
    else                      pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      adv <= 1'b0;
    end else begin
      adv <= tick & ~host_wr;
      if (host_wr) begin
        if (wr_lo) cnt[7:0]       <= wr_data;
        if (wr_hi) cnt[CNT_W-1:8] <= wr_data;
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!run && !host_wr) |=> $stable(cnt)) else $error("counter moved while stopped"); // R1

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (cnt == '0)) else $error("overflow did not wrap"); // R2

  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (rst)
    pre <= PMAX) else $error("prescaler out of range"); // R3

  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (idle && idle_stop && !host_wr) |=> $stable(cnt)) else $error("counted in idle"); // R9
endmodule

// File: rtl/cca_cell.sv
module cca_cell
  import cca_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  mode_t            mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic             adv,
  input  logic             cap_in,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       wr_data,
  output logic [CNT_W-1:0] cval,
  output logic             flag_set,
  output logic             out
);
  logic s1, s2, s3;
  logic rise, fall, cap_evt, match, lo_wrap, host_wr;

  assign rise    = s2 & ~s3;
  assign fall    = ~s2 & s3;
  assign cap_evt = (rise & mode.cap_pos) | (fall & mode.cap_neg);
  assign match   = mode.cmp_en & adv & (cnt == cval);
  assign lo_wrap = adv & (cnt[7:0] == 8'h00);
  assign host_wr = wr_lo | wr_hi;
  assign flag_set = cap_evt | (match & mode.match_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= cap_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cval <= '0;
    end else if (host_wr) begin
      if (wr_lo) cval[7:0]       <= wr_data;
      if (wr_hi) cval[CNT_W-1:8] <= wr_data;
    end else if (cap_evt) begin
      cval <= cnt;
    end else if (mode.pwm_en && lo_wrap) begin
      cval[7:0] <= cval[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                        out <= 1'b0;
    else if (mode.pwm_en)           out <= (cnt[7:0] >= cval[7:0]);
    else if (mode.tog_en && match)  out <= ~out;
  end

  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && !host_wr) |=> (cval == $past(cnt))) else $error("capture value wrong"); // R6

  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (rst)
    (match && mode.tog_en && !mode.pwm_en) |=> (out != $past(out))) else $error("no toggle"); // R7

  AST_PWM_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (mode.pwm_en && lo_wrap && !host_wr && !cap_evt) |=> (cval[7:0] == $past(cval[15:8])))
    else $error("pwm reload missing"); // R8
endmodule

// File: rtl/cca_top.sv
module cca_top
  import cca_pkg::*;
#(
  parameter int NMOD = 5,
  parameter int DIV  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tmr_ovf,
  input  logic              ext_cnt,
  input  logic [NMOD-1:0]   cap_in,
  input  logic              idle,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic [NMOD-1:0]   mod_out,
  output logic              irq,
  output logic              ovf_flag,
  output logic [NMOD-1:0]   mod_flag
);
  logic       run, idle_stop, ovf_ie;
  src_e       src;
  mode_t      modes [NMOD];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cvals [NMOD];
  logic [NMOD-1:0]  fset, ie_vec;
  logic       adv, ovf, ctrl_wr;

  assign ctrl_wr = wr_en && (addr == A_CTRL);

  cca_timebase #(.DIV(DIV)) u_tb (
    .clk(clk), .rst(rst), .run(run), .idle(idle), .idle_stop(idle_stop),
    .src(src), .tmr_ovf(tmr_ovf), .ext_cnt(ext_cnt),
    .wr_lo(wr_en && addr == A_CNT_LO), .wr_hi(wr_en && addr == A_CNT_HI),
    .wr_data(wr_data), .cnt(cnt), .adv(adv), .ovf(ovf)
  );

  for (genvar g = 0; g < NMOD; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) modes[g] <= '0;
      else if (wr_en && addr == ADDR_W'(B_MODE + g)) modes[g] <= wr_data[6:0];
    end
    assign ie_vec[g] = modes[g].flag_ie;

    cca_cell u_cell (
      .clk(clk), .rst(rst), .mode(modes[g]), .cnt(cnt), .adv(adv),
      .cap_in(cap_in[g]),
      .wr_lo(wr_en && addr == ADDR_W'(B_VLO + g)),
      .wr_hi(wr_en && addr == ADDR_W'(B_VHI + g)),
      .wr_data(wr_data), .cval(cvals[g]), .flag_set(fset[g]), .out(mod_out[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      ovf_flag <= 1'b0;
      mod_flag <= '0;
    end else if (ctrl_wr) begin
      run      <= wr_data[6];
      ovf_flag <= (ovf_flag & wr_data[7]) | ovf;
      mod_flag <= (mod_flag & wr_data[NMOD-1:0]) | fset;
    end else begin
      ovf_flag <= ovf_flag | ovf;
      mod_flag <= mod_flag | fset;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_stop <= 1'b0;
      src       <= SRC_DIV_A;
      ovf_ie    <= 1'b0;
    end else if (wr_en && addr == A_CFG) begin
      idle_stop <= wr_data[7];
      src       <= src_e'(wr_data[2:1]);
      ovf_ie    <= wr_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (ovf_flag & ovf_ie) | (|(mod_flag & ie_vec));
  end

  logic [7:0] rd_next;
  always_comb begin
    rd_next = 8'h00;
    unique case (addr)
      A_CTRL: begin
        rd_next[7] = ovf_flag;
        rd_next[6] = run;
        rd_next[NMOD-1:0] = mod_flag;
      end
      A_CFG:    rd_next = {idle_stop, 4'b0000, src, ovf_ie};
      A_CNT_LO: rd_next = cnt[7:0];
      A_CNT_HI: rd_next = cnt[15:8];
      default: ;
    endcase
    for (int i = 0; i < NMOD; i++) begin
      if (addr == ADDR_W'(B_MODE + i)) rd_next = {1'b0, modes[i]};
      if (addr == ADDR_W'(B_VLO + i))  rd_next = cvals[i][7:0];
      if (addr == ADDR_W'(B_VHI + i))  rd_next = cvals[i][15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'h00;
    else     rd_data <= rd_next;
  end

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr |=> ((mod_flag & $past(mod_flag)) == $past(mod_flag))) else $error("flag lost"); // R11

  AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf_flag) else $error("overflow flag not set"); // R2

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!ovf_flag && mod_flag == '0) |=> !irq) else $error("spurious irq"); // R10
endmodule

// File: tb/sim_cca_top.sv
module sim_cca_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tmr_ovf = 1'b0, ext_cnt = 1'b0, idle = 1'b0, wr_en = 1'b0;
  logic [4:0] cap_in = '0;
  logic [4:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [4:0] mod_out, mod_flag;
  logic irq, ovf_flag;

  always #5 clk = ~clk;

  cca_top u0 (
    .clk(clk), .rst(rst), .tmr_ovf(tmr_ovf), .ext_cnt(ext_cnt), .cap_in(cap_in),
    .idle(idle), .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .mod_out(mod_out), .irq(irq), .ovf_flag(ovf_flag), .mod_flag(mod_flag)
  );

  typedef struct {
    bit    is_port;
    int    sel;
    logic [7:0] exp;
    string tag;
  } item_t;

  item_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // monitor: compares one expected item right after the edge that produced it
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = exp_q.pop_front();
      if (it.is_port) act = {1'b0, {mod_out, ovf_flag, irq}}[it.sel] ? 8'd1 : 8'd0;
      else            act = rd_data;
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk); addr = a;
    it.is_port = 0; it.sel = 0; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  // sel: 0 irq, 1 ovf_flag, 2+i mod_out[i]
  task automatic pchk(input int sel, input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_port = 1; it.sel = sel; it.exp = {7'd0, e}; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tmr_ovf = 1'b1;
      @(negedge clk); tmr_ovf = 1'b0;
    end
  endtask

  task automatic idle_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    rd(2, 8'h00, "R1 reset count");
    rd(0, 8'h00, "R11 reset flags");
    pchk(0, 1'b0, "R10 reset irq");
    pchk(2, 1'b0, "R7 reset output");

    // R1 run control with timer strobe source (code 10)
    wr(1, 8'h04); wr(0, 8'h40);
    pulse(5);
    rd(2, 8'h05, "R4 timer strobe count");
    wr(0, 8'h00);
    pulse(3);
    rd(2, 8'h05, "R1 stopped holds");

    // R3 internal prescaler: 62 enabled edges -> 10 advances
    wr(2, 8'h00); wr(3, 8'h00); wr(1, 8'h00);
    wr(0, 8'h40);
    idle_cyc(60);
    wr(0, 8'h00);
    rd(2, 8'h0A, "R3 divide by six");

    // R4 external pin
    wr(2, 8'h00); wr(1, 8'h06); wr(0, 8'h40);
    for (int k = 0; k < 4; k++) begin
      ext_cnt = 1'b1; idle_cyc(4);
      ext_cnt = 1'b0; idle_cyc(4);
    end
    idle_cyc(4);
    wr(0, 8'h00);
    rd(2, 8'h04, "R4 external edges");

    // R2 overflow, R10 enable gating
    wr(1, 8'h04); wr(2, 8'hFF); wr(3, 8'hFF);
    wr(0, 8'hC0);
    pulse(1); idle_cyc(3);
    rd(2, 8'h00, "R2 wrap low");
    rd(3, 8'h00, "R2 wrap high");
    rd(0, 8'hC0, "R2 overflow flag");
    pchk(1, 1'b1, "R2 ovf_flag pin");
    pchk(0, 1'b0, "R10 irq masked");
    wr(1, 8'h05); idle_cyc(2);
    pchk(0, 1'b1, "R10 irq enabled");

    // R11 clearing
    wr(0, 8'h40); idle_cyc(2);
    rd(0, 8'h40, "R11 cleared");
    pchk(0, 1'b0, "R10 irq after clear");
    wr(0, 8'hDF); idle_cyc(2);
    rd(0, 8'h40, "R11 write one sets nothing");
    wr(1, 8'h04); wr(0, 8'h00);

    // R5 match flag on cell 0
    wr(8, 8'h49); wr(16, 8'h10); wr(24, 8'h00);
    wr(2, 8'h0E); wr(3, 8'h00);
    wr(0, 8'h40);
    pulse(1); idle_cyc(2);
    rd(0, 8'h40, "R5 no early match");
    pulse(1); idle_cyc(2);
    rd(0, 8'h41, "R5 match flag");
    pchk(0, 1'b1, "R10 cell irq");
    wr(0, 8'h00); wr(8, 8'h00);

    // R7 toggle on cell 1
    wr(9, 8'h44); wr(17, 8'h03); wr(25, 8'h00);
    wr(2, 8'h02); wr(0, 8'h40);
    pulse(1); idle_cyc(2);
    pchk(3, 1'b1, "R7 toggle high");
    wr(2, 8'h02);
    pulse(1); idle_cyc(2);
    pchk(3, 1'b0, "R7 toggle low");
    rd(0, 8'h40, "R7 no flag without match enable");
    wr(0, 8'h00); wr(9, 8'h00);

    // R6 captures
    wr(10, 8'h20); wr(2, 8'h34); wr(3, 8'h12);
    cap_in[2] = 1'b1; idle_cyc(5);
    rd(18, 8'h34, "R6 rise capture low");
    rd(26, 8'h12, "R6 rise capture high");
    rd(0, 8'h04, "R6 capture flag");
    wr(0, 8'h00);
    wr(2, 8'h22); wr(3, 8'h22);
    cap_in[2] = 1'b0; idle_cyc(5);
    rd(18, 8'h34, "R6 falling edge ignored");
    rd(0, 8'h00, "R6 no flag on ignored edge");
    wr(11, 8'h30); wr(2, 8'h11);
    cap_in[3] = 1'b1; idle_cyc(5);
    rd(19, 8'h11, "R6 both edges rise");
    wr(2, 8'h77);
    cap_in[3] = 1'b0; idle_cyc(5);
    rd(19, 8'h77, "R6 both edges fall");
    wr(0, 8'h00); wr(10, 8'h00); wr(11, 8'h00);

    // R8 PWM on cell 4
    wr(12, 8'h02); wr(20, 8'h40); wr(28, 8'h40);
    wr(2, 8'h20); wr(3, 8'h00); idle_cyc(2);
    pchk(6, 1'b0, "R8 below threshold");
    wr(2, 8'h50); idle_cyc(2);
    pchk(6, 1'b1, "R8 above threshold");
    wr(28, 8'hC0); wr(2, 8'hFF);
    wr(0, 8'h40);
    pulse(1); idle_cyc(3);
    rd(20, 8'hC0, "R8 reload on wrap");
    pchk(6, 1'b0, "R8 low after wrap");
    wr(0, 8'h00); wr(2, 8'h50); idle_cyc(2);
    pchk(6, 1'b0, "R8 new duty used");
    wr(12, 8'h00);

    // R9 idle
    wr(2, 8'h00); wr(3, 8'h00); wr(1, 8'h84); wr(0, 8'h40);
    idle = 1'b1;
    pulse(2); idle_cyc(2);
    rd(2, 8'h00, "R9 idle stops");
    wr(1, 8'h04);
    pulse(2); idle_cyc(2);
    rd(2, 8'h02, "R9 idle ignored");
    idle = 1'b0;

    idle_cyc(4);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule